// File: doc/BRIEF.md
# Keyboard and Character Display Register Block

This block gives a processor a keyboard and a character display through two small sets of registers on its memory bus. Each device has a status word and a data word. The processor decodes nothing itself. It reads or writes one of four word addresses, and the block returns read data in the same cycle as the read strobe. Register state changes at the clock edge that ends the access cycle.

A keyboard-side source delivers one 8-bit character code with a one-cycle strobe. The block latches the code and raises the keyboard ready flag. The flag stays set until the processor reads the keyboard data word, and further characters are refused while it is set.

On the display side, the processor writes a character only while the display ready flag is up. That write clears the flag, puts the character on an output bus with a one-cycle strobe, and waits for the display to return a done pulse. Each device raises its interrupt request whenever its ready flag and its enable bit are both set.

Top module: `console_io_regs`

## Requirements
- R1: After a synchronous reset the keyboard status word reads 0x0000, the display status word reads 0x8000, both data words read 0x0000 and both interrupt requests are low.
- R2: The four registers sit at BASE+0 (keyboard status), BASE+2 (keyboard data), BASE+4 (display status) and BASE+6 (display data), with BASE = 0xFE00. Any other address reads 0x0000, and a write to it changes nothing. When the read strobe is low, the read data is 0x0000.
- R3: A keyboard strobe while keyboard ready is 0 stores the character in keyboard data bits 7:0 and sets keyboard ready (status bit 15) at the same clock edge.
- R4: A read of the keyboard data word returns the held character in bits 7:0 and clears keyboard ready at the edge that ends the read cycle.
- R5: A keyboard strobe while keyboard ready is 1 is refused, and the held character is unchanged.
- R6: A write to the display data word while display ready is 1 clears display ready. It also places wdata bits 7:0 on the character output, with the output strobe high for exactly the one cycle after the write.
- R7: A write to the display data word while display ready is 0 is ignored: there is no strobe and the character output is unchanged.
- R8: A done pulse while display ready is 0 sets display ready at that edge.
- R9: Status bit 14 is a read/write interrupt enable. Writes to status bit 15 and to data words are ignored (display data only takes a write as in R6). All status bits 13:0 and data bits 15:8 read as zero.
- R10: Each interrupt request equals that device's ready flag ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Word address of the access |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| key_stb | input | 1 | One-cycle strobe: a character is offered |
| key_char | input | 8 | Offered character code |
| disp_stb | output | 1 | One-cycle strobe: a new character for the display |
| disp_char | output | 8 | Character last accepted for the display |
| disp_done | input | 1 | Display finished the current character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| dsp_irq | output | 1 | Display interrupt request |

## Verification
The bench builds the block with its default base of 0xFE00, 16-bit words and 8-bit characters. This makes the exact decode boundaries reachable: odd addresses inside the window, the word just past it, and an address that aliases the window only in its low bits. With these widths, the ready flag and the enable bit land at bits 15 and 14. The bench can then show that a write of all ones cannot set ready. It can also show that a keystroke arriving while ready is set leaves the held code untouched, and that a second display write during a busy period produces no strobe.

// File: rtl/console_io_pkg.sv
package console_io_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int CHAR_W = 8;

    localparam int RDY_BIT = DATA_W - 1;
    localparam int IE_BIT  = DATA_W - 2;

    localparam logic [ADDR_W-1:0] KSTAT_OFF = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] KDATA_OFF = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] DSTAT_OFF = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] DDATA_OFF = ADDR_W'(6);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA
    } reg_sel_e;

    typedef struct packed {
        logic kstat_wr;
        logic kdata_rd;
        logic dstat_wr;
        logic ddata_wr;
    } strobe_t;

    typedef struct packed {
        logic              ready;
        logic              ie;
        logic [CHAR_W-1:0] chr;
    } chan_state_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr,
                                            input logic [ADDR_W-1:0] base);
        reg_sel_e s;
        if      (addr == ADDR_W'(base + KSTAT_OFF)) s = SEL_KSTAT;
        else if (addr == ADDR_W'(base + KDATA_OFF)) s = SEL_KDATA;
        else if (addr == ADDR_W'(base + DSTAT_OFF)) s = SEL_DSTAT;
        else if (addr == ADDR_W'(base + DDATA_OFF)) s = SEL_DDATA;
        else                                        s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic rdy, input logic ie);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[RDY_BIT] = rdy;
        w[IE_BIT]  = ie;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] data_word(input logic [CHAR_W-1:0] c);
        return {{(DATA_W-CHAR_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/cio_decode.sv
module cio_decode
    import console_io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output strobe_t           stb
);

    always_comb begin
        sel          = decode_sel(addr, BASE_ADDR);
        stb          = '0;
        stb.kstat_wr = wr && (sel == SEL_KSTAT);
        stb.kdata_rd = rd && (sel == SEL_KDATA);
        stb.dstat_wr = wr && (sel == SEL_DSTAT);
        stb.ddata_wr = wr && (sel == SEL_DDATA);
    end

endmodule

// File: rtl/cio_kbd_chan.sv
module cio_kbd_chan
    import console_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_stb,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              stat_wr,
    input  logic              ie_in,
    input  logic              data_rd,
    output chan_state_t       st
);

    chan_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (stat_wr) st_q.ie <= ie_in;
            if (!st_q.ready && key_stb) begin
                st_q.chr   <= key_char;
                st_q.ready <= 1'b1;
            end else if (st_q.ready && data_rd) begin
                st_q.ready <= 1'b0;
            end
        end
    end

    assign st = st_q;

    assert_key_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.ready && key_stb) |=> $stable(st_q.chr));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.ready && data_rd) |=> !st_q.ready);

    assert_key_sets_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (!st_q.ready && key_stb) |=> (st_q.ready && st_q.chr == $past(key_char)));

endmodule

// File: rtl/cio_dsp_chan.sv
module cio_dsp_chan
    import console_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_wr,
    input  logic              ie_in,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              done,
    output chan_state_t       st,
    output logic              out_stb
);

    chan_state_t st_q;
    logic        stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ready <= 1'b1;
            st_q.ie    <= 1'b0;
            st_q.chr   <= '0;
            stb_q      <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (stat_wr) st_q.ie <= ie_in;
            if (st_q.ready && data_wr) begin
                st_q.chr   <= wchar;
                st_q.ready <= 1'b0;
                stb_q      <= 1'b1;
            end else if (!st_q.ready && done) begin
                st_q.ready <= 1'b1;
            end
        end
    end

    assign st      = st_q;
    assign out_stb = stb_q;

    assert_busy_write_R7: assert property (@(posedge clk) disable iff (rst)
        (!st_q.ready && data_wr) |=> ($stable(st_q.chr) && !stb_q));

    assert_done_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (!st_q.ready && done) |=> st_q.ready);

    assert_stb_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q);

    assert_stb_busy_R6: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> !st_q.ready);

endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
    import console_io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_stb,
    input  logic [CHAR_W-1:0] key_char,
    output logic              disp_stb,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_done,
    output logic              kbd_irq,
    output logic              dsp_irq
);

    reg_sel_e    sel;
    strobe_t     stb;
    chan_state_t k_st;
    chan_state_t d_st;

    cio_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .sel  (sel),
        .stb  (stb)
    );

    cio_kbd_chan u_kbd (
        .clk      (clk),
        .rst      (rst),
        .key_stb  (key_stb),
        .key_char (key_char),
        .stat_wr  (stb.kstat_wr),
        .ie_in    (bus_wdata[IE_BIT]),
        .data_rd  (stb.kdata_rd),
        .st       (k_st)
    );

    cio_dsp_chan u_dsp (
        .clk     (clk),
        .rst     (rst),
        .stat_wr (stb.dstat_wr),
        .ie_in   (bus_wdata[IE_BIT]),
        .data_wr (stb.ddata_wr),
        .wchar   (bus_wdata[CHAR_W-1:0]),
        .done    (disp_done),
        .st      (d_st),
        .out_stb (disp_stb)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_KSTAT: bus_rdata = status_word(k_st.ready, k_st.ie);
                SEL_KDATA: bus_rdata = data_word(k_st.chr);
                SEL_DSTAT: bus_rdata = status_word(d_st.ready, d_st.ie);
                SEL_DDATA: bus_rdata = data_word(d_st.chr);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign disp_char = d_st.chr;
    assign kbd_irq   = k_st.ready & k_st.ie;
    assign dsp_irq   = d_st.ready & d_st.ie;

    assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE) |=> ($stable(k_st.ie) && $stable(d_st.ie)));

    assert_kbd_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (stb.kstat_wr && !bus_wdata[IE_BIT]) |=> !kbd_irq);

    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/sim_console_io_regs.sv
module sim_console_io_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        key_stb = 1'b0;
    logic [7:0]  key_char = '0;
    logic        disp_stb;
    logic [7:0]  disp_char;
    logic        disp_done = 1'b0;
    logic        kbd_irq;
    logic        dsp_irq;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    localparam logic [15:0] KST = 16'hFE00;
    localparam logic [15:0] KDT = 16'hFE02;
    localparam logic [15:0] DST = 16'hFE04;
    localparam logic [15:0] DDT = 16'hFE06;

    always #10 clk = ~clk;

    console_io_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_stb(key_stb),
        .key_char(key_char), .disp_stb(disp_stb), .disp_char(disp_char),
        .disp_done(disp_done), .kbd_irq(kbd_irq), .dsp_irq(dsp_irq)
    );

    // monitor: pops one expected word per read cycle
    always @(negedge clk) begin
        if (!rst && bus_rd) begin
            logic [15:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== e) begin
                n_fails++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic drive(input logic rd, input logic wr, input logic [15:0] a,
                         input logic [15:0] wd, input logic ks, input logic [7:0] kc,
                         input logic dn);
        @(posedge clk);
        #2;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        key_stb = ks; key_char = kc; disp_done = dn;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        drive(1'b1, 1'b0, a, 16'h0, 1'b0, 8'h0, 1'b0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        drive(1'b0, 1'b1, a, d, 1'b0, 8'h0, 1'b0);
    endtask

    task automatic key(input logic [7:0] c);
        drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, c, 1'b0);
    endtask

    task automatic done_pulse();
        drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b0);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] e, input string t);
        n_checks++;
        if (act !== e) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    // idle cycle, then sample outputs at its negedge
    task automatic look(output logic ki, output logic di, output logic ds,
                        output logic [7:0] dc);
        idle();
        @(negedge clk);
        ki = kbd_irq; di = dsp_irq; ds = disp_stb; dc = disp_char;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        logic ki, di, ds;
        logic [7:0] dc;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        look(ki, di, ds, dc);
        chk({14'h0, ki, di}, 16'h0, "R1 irqs");
        rd(KST, 16'h0000, "R1 kbd status");
        rd(DST, 16'h8000, "R1 dsp status");
        rd(KDT, 16'h0000, "R1 kbd data");
        rd(DDT, 16'h0000, "R1 dsp data");

        // R3, R4 key arrival and read
        key(8'h41);
        rd(KST, 16'h8000, "R3 kbd ready set");
        rd(KDT, 16'h0041, "R4 kbd data read");
        rd(KST, 16'h0000, "R4 ready cleared");

        // R5 lockout
        key(8'h42);
        key(8'h43);
        rd(KDT, 16'h0042, "R5 second key refused");
        rd(KST, 16'h0000, "R5 ready cleared after read");

        // R9 enable writable, ready and data ignored
        wr(KDT, 16'hFFFF);
        rd(KDT, 16'h0042, "R9 kbd data write ignored");
        wr(KST, 16'hC000);
        rd(KST, 16'h4000, "R9 ie set ready unchanged");
        look(ki, di, ds, dc);
        chk({15'h0, ki}, 16'h0, "R10 kbd irq low when not ready");
        key(8'h5A);
        look(ki, di, ds, dc);
        chk({15'h0, ki}, 16'h1, "R10 kbd irq high");
        rd(KDT, 16'h005A, "R4 data with ie set");
        look(ki, di, ds, dc);
        chk({15'h0, ki}, 16'h0, "R10 kbd irq drops after read");
        wr(KST, 16'h0000);
        rd(KST, 16'h0000, "R9 ie cleared");

        // R6 display write
        wr(DDT, 16'h1234);
        look(ki, di, ds, dc);
        chk({7'h0, ds, dc}, {7'h0, 1'b1, 8'h34}, "R6 strobe and char");
        look(ki, di, ds, dc);
        chk({15'h0, ds}, 16'h0, "R6 strobe single cycle");
        rd(DST, 16'h0000, "R6 dsp ready cleared");
        rd(DDT, 16'h0034, "R9 dsp data upper bits zero");

        // R7 busy write ignored
        wr(DDT, 16'h0055);
        look(ki, di, ds, dc);
        chk({7'h0, ds, dc}, {7'h0, 1'b0, 8'h34}, "R7 busy write ignored");
        rd(DDT, 16'h0034, "R7 data unchanged");

        // R8 done
        done_pulse();
        rd(DST, 16'h8000, "R8 ready after done");

        // R10 display irq
        wr(DST, 16'h4000);
        look(ki, di, ds, dc);
        chk({15'h0, di}, 16'h1, "R10 dsp irq high");
        rd(DST, 16'hC000, "R9 dsp ie readback");
        wr(DDT, 16'h0007);
        look(ki, di, ds, dc);
        chk({14'h0, di, ds}, 16'h1, "R10 dsp irq low while busy");
        done_pulse();
        look(ki, di, ds, dc);
        chk({15'h0, di}, 16'h1, "R10 dsp irq after done");

        // R2 decode boundaries
        rd(16'hFE01, 16'h0000, "R2 odd address");
        rd(16'hFE08, 16'h0000, "R2 past window");
        rd(16'h0E04, 16'h0000, "R2 alias address");
        wr(16'h0E04, 16'h0000);
        wr(16'hFE05, 16'h0000);
        rd(DST, 16'hC000, "R2 unmapped writes ignored");
        idle();
        @(negedge clk);
        chk(bus_rdata, 16'h0000, "R2 rdata zero without read");

        idle();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule